// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This unit watches the running minute, hour, day-of-month and weekday values of a calendar and raises an alarm when the time reaches a programmed moment. There are four alarm registers, one for each of those fields. Each register holds a BCD value in its low bits and a field-enable bit in bit 7. Each field can be excluded from the comparison on its own, so the same unit serves as a daily, weekly or monthly alarm.

The comparison runs only when the time counter signals an increment. The alarm flag then latches on the first increment that brings the enabled fields into agreement. It stays latched until the host clears it through a write to the flag register. That write is ANDed with the flag, so a host can clear one flag without touching others. An active-low interrupt line mirrors the flag whenever the interrupt enable input is high.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset the alarm flag is 0, `irq_n_o` is 1, and all four alarm registers read as excluded (bit 7 = 1), so ticks alone raise nothing.
- R2: A field takes part in the compare when bit 7 of its alarm register is 0. Bits [6:0] must then equal the matching current-time input. A field with bit 7 = 1 is ignored whatever its value.
- R3: On a cycle with `tick_i` = 1, the flag sets when at least one field is enabled, every enabled field agrees, and the previous tick did not see a match.
- R4: While a match persists over several ticks, a cleared flag is not set again. Only a later tick that enters the match anew sets it.
- R5: The flag holds until a write to select 4 with data bit 0 = 0 clears it. A write to select 4 with bit 0 = 1 leaves the flag unchanged.
- R6: The flag never sets on a cycle without `tick_i`. A write to an alarm register alone cannot set it.
- R7: When all four fields are excluded, no tick ever sets the flag.
- R8: `irq_n_o` is 0 exactly when `aie_i` = 1 and the flag is 1. With `aie_i` = 0 it stays at 1.
- R9: When a tick sets the flag in the same cycle as a host write clears it, the flag ends up set.
- R10: Write select encoding: 0 = minute, 1 = hour, 2 = day, 3 = weekday, 4 = flag register. Writes with selects 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Time-increment strobe; current time inputs already hold the new value |
| cur_min_i | input | 7 | Current minute, BCD |
| cur_hour_i | input | 7 | Current hour, BCD |
| cur_day_i | input | 7 | Current day of month, BCD |
| cur_wday_i | input | 7 | Current weekday |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select (see R10) |
| wr_data_i | input | 8 | Write data |
| aie_i | input | 1 | Alarm interrupt enable |
| alarm_flag_o | output | 1 | Latched alarm flag |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
Two events can land in the same cycle: a tick that enters a match, and a host write that clears the flag. The bench lines up both by moving the minute away, ticking, and then ticking back into the match while writing zero to the flag register in that same cycle. The flag must read set afterwards (R9). A behavioural model that applies the clear before the set judges this cycle and every other cycle. A second case pairs an alarm-register write with an idle tick line, to show the write alone sets nothing.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int unsigned NUM_FIELDS = 4;
  localparam int unsigned SEL_W      = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_MIN  = 3'd0,
    SEL_HOUR = 3'd1,
    SEL_DAY  = 3'd2,
    SEL_WDAY = 3'd3,
    SEL_FLAG = 3'd4
  } wsel_e;
endpackage

// File: rtl/cam_field_cmp.sv
module cam_field_cmp #(
  parameter int unsigned VAL_W = 7
) (
  input  logic [VAL_W:0]   alarm_reg_i,
  input  logic [VAL_W-1:0] cur_i,
  output logic             en_o,
  output logic             ok_o
);
  logic excluded;

  always_comb begin
    excluded = alarm_reg_i[VAL_W];
    en_o     = ~excluded;
    ok_o     = excluded | (alarm_reg_i[VAL_W-1:0] == cur_i);
  end
endmodule

// File: rtl/cam_alarm_regs.sv
module cam_alarm_regs
  import cam_pkg::*;
#(
  parameter int unsigned VAL_W = 7,
  parameter int unsigned NUM   = NUM_FIELDS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic [SEL_W-1:0]          wr_sel_i,
  input  logic [VAL_W:0]            wr_data_i,
  output logic [NUM-1:0][VAL_W:0]   regs_o
);
  localparam logic [VAL_W:0] RST_VAL = {1'b1, {VAL_W{1'b0}}};

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    logic           we;
    logic [VAL_W:0] d;
    logic [VAL_W:0] q;

    always_comb begin
      we = wr_en_i && (wr_sel_i == SEL_W'(g));
      d  = we ? wr_data_i : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= RST_VAL;
      end else if (we) begin
        q <= d;
      end
    end

    assign regs_o[g] = q;
  end
endmodule

// File: rtl/cam_flag_ctrl.sv
module cam_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic match_i,
  input  logic flag_wr_i,
  input  logic flag_keep_i,
  output logic flag_o
);
  logic match_q, match_d;
  logic flag_q, flag_d;
  logic set_evt;

  always_comb begin
    set_evt = tick_i & match_i & ~match_q;
    match_d = tick_i ? match_i : match_q;
    flag_d  = flag_q;
    if (flag_wr_i) begin
      flag_d = flag_q & flag_keep_i;
    end
    if (set_evt) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (tick_i) begin
        match_q <= match_d;
      end
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cam_pkg::*;
#(
  parameter int unsigned VAL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [VAL_W-1:0] cur_min_i,
  input  logic [VAL_W-1:0] cur_hour_i,
  input  logic [VAL_W-1:0] cur_day_i,
  input  logic [VAL_W-1:0] cur_wday_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [VAL_W:0]   wr_data_i,
  input  logic             aie_i,
  output logic             alarm_flag_o,
  output logic             irq_n_o
);
  localparam int unsigned NUM = NUM_FIELDS;

  logic                        rst_meta, rst_sync_n;
  logic [NUM-1:0][VAL_W:0]     alarm_q;
  logic [NUM-1:0][VAL_W-1:0]   cur_vec;
  logic [NUM-1:0]              en_vec;
  logic [NUM-1:0]              ok_vec;
  logic                        match_now;
  logic                        flag_wr;
  logic                        flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    cur_vec[SEL_MIN]  = cur_min_i;
    cur_vec[SEL_HOUR] = cur_hour_i;
    cur_vec[SEL_DAY]  = cur_day_i;
    cur_vec[SEL_WDAY] = cur_wday_i;
  end

  cam_alarm_regs #(.VAL_W(VAL_W), .NUM(NUM)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .regs_o    (alarm_q)
  );

  for (genvar g = 0; g < NUM; g++) begin : g_cmp
    cam_field_cmp #(.VAL_W(VAL_W)) u_cmp (
      .alarm_reg_i (alarm_q[g]),
      .cur_i       (cur_vec[g]),
      .en_o        (en_vec[g]),
      .ok_o        (ok_vec[g])
    );
  end

  always_comb begin
    match_now = (|en_vec) & (&ok_vec);
    flag_wr   = wr_en_i && (wr_sel_i == SEL_FLAG);
  end

  cam_flag_ctrl u_flag (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tick_i      (tick_i),
    .match_i     (match_now),
    .flag_wr_i   (flag_wr),
    .flag_keep_i (wr_data_i[0]),
    .flag_o      (flag_q)
  );

  always_comb begin
    alarm_flag_o = flag_q;
    irq_n_o      = ~(aie_i & flag_q);
  end
endmodule

// File: rtl/cam_checker.sv
module cam_checker #(
  parameter int unsigned VAL_W = 7,
  parameter int unsigned NUM   = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick_i,
  input logic           wr_en_i,
  input logic [2:0]     wr_sel_i,
  input logic [VAL_W:0] wr_data_i,
  input logic           aie_i,
  input logic [NUM-1:0] en_vec,
  input logic           alarm_flag_o,
  input logic           irq_n_o
);
  // R5: held unless a clearing write arrives
  a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag_o && !(wr_en_i && wr_sel_i == 3'd4 && !wr_data_i[0])) |=> alarm_flag_o);

  // R5: clearing write without a tick drops the flag
  a_r5_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 3'd4 && !wr_data_i[0] && !tick_i) |=> !alarm_flag_o);

  // R6: a rising flag needs a tick on the edge that set it
  a_r6_set_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag_o) |-> $past(tick_i));

  // R7: nothing enabled, nothing raised
  a_r7_all_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec == '0 && !alarm_flag_o) |=> !alarm_flag_o);

  // R8: interrupt gating
  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !aie_i |-> irq_n_o);

  a_r8_irq_active: assert property (@(posedge clk) disable iff (!rst_n)
    (aie_i && alarm_flag_o) |-> !irq_n_o);
endmodule

bind cal_alarm_match cam_checker #(.VAL_W(VAL_W), .NUM(NUM)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_i       (tick_i),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .wr_data_i    (wr_data_i),
  .aie_i        (aie_i),
  .en_vec       (en_vec),
  .alarm_flag_o (alarm_flag_o),
  .irq_n_o      (irq_n_o)
);

// File: tb/cal_alarm_match_bench.sv
`timescale 1ns/1ps
module cal_alarm_match_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic [6:0] cur_min_i = '0, cur_hour_i = '0, cur_day_i = '0, cur_wday_i = '0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       aie_i = 1'b0;
  logic       alarm_flag_o, irq_n_o;

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  cal_alarm_match u_cal_alarm_match (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .cur_min_i(cur_min_i), .cur_hour_i(cur_hour_i),
    .cur_day_i(cur_day_i), .cur_wday_i(cur_wday_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .aie_i(aie_i), .alarm_flag_o(alarm_flag_o), .irq_n_o(irq_n_o)
  );

  // behavioural reference
  logic [7:0] m_al [4];
  bit m_flag, m_prev, m_any, m_all, m_hit;
  logic [6:0] m_cur [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_al[i]) m_al[i] = 8'h80;
      m_flag = 0;
      m_prev = 0;
    end else begin
      m_cur[0] = cur_min_i; m_cur[1] = cur_hour_i;
      m_cur[2] = cur_day_i; m_cur[3] = cur_wday_i;
      m_any = 0; m_all = 1;
      foreach (m_al[i]) begin
        if (!m_al[i][7]) begin
          m_any = 1;
          if (m_al[i][6:0] != m_cur[i]) m_all = 0;
        end
      end
      m_hit = m_any && m_all;
      if (wr_en_i && wr_sel_i == 3'd4 && !wr_data_i[0]) m_flag = 0;
      if (tick_i && m_hit && !m_prev) m_flag = 1;
      if (tick_i) m_prev = m_hit;
      if (wr_en_i && wr_sel_i < 3'd4) m_al[wr_sel_i[1:0]] = wr_data_i;
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic model_cmp();
    check(cur_req, alarm_flag_o, m_flag, "flag vs model");
    check(cur_req, irq_n_o, ~(aie_i & m_flag), "irq_n vs model");
  endtask

  // drive one cycle from a negedge, compare at the next negedge
  task automatic step(input bit tk, input bit we, input logic [2:0] sel, input logic [7:0] d);
    tick_i = tk; wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk);
    tick_i = 0; wr_en_i = 0;
    model_cmp();
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    step(0, 1, sel, d);
  endtask

  task automatic tk();
    step(1, 0, 3'd0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cur_req = "R1";
    check("R1", alarm_flag_o, 1'b0, "reset flag");
    check("R1", irq_n_o, 1'b1, "reset irq_n");

    cur_min_i = 7'h30; cur_hour_i = 7'h12; cur_day_i = 7'h15; cur_wday_i = 7'h03;
    aie_i = 1;
    cur_req = "R7";
    for (int i = 0; i < 3; i++) tk();
    check("R7", alarm_flag_o, 1'b0, "all excluded, ticks");
    check("R1", irq_n_o, 1'b1, "no irq after reset ticks");

    cur_req = "R6";
    wr(3'd0, 8'h30);               // minute enabled, matches now
    wr(3'd0, 8'h30);
    check("R6", alarm_flag_o, 1'b0, "write alone sets nothing");

    cur_req = "R3";
    tk();
    check("R3", alarm_flag_o, 1'b1, "tick into match sets");
    check("R8", irq_n_o, 1'b0, "irq low with aie");

    cur_req = "R5";
    tk();
    wr(3'd4, 8'h01);
    check("R5", alarm_flag_o, 1'b1, "write 1 keeps flag");
    cur_req = "R10";
    wr(3'd5, 8'h00);
    wr(3'd7, 8'h00);
    check("R10", alarm_flag_o, 1'b1, "unused selects ignored");
    cur_req = "R5";
    wr(3'd4, 8'h00);
    check("R5", alarm_flag_o, 1'b0, "write 0 clears");

    cur_req = "R4";
    tk(); tk();
    check("R4", alarm_flag_o, 1'b0, "persisting match does not re-set");

    cur_req = "R3";
    cur_min_i = 7'h31; tk();
    check("R3", alarm_flag_o, 1'b0, "no match");
    cur_min_i = 7'h30; tk();
    check("R3", alarm_flag_o, 1'b1, "re-entry sets");

    cur_req = "R8";
    aie_i = 0;
    #1;
    check("R8", irq_n_o, 1'b1, "aie low masks irq");
    aie_i = 1;

    cur_req = "R2";
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h11);               // hour enabled, mismatched
    cur_min_i = 7'h31; tk();
    cur_min_i = 7'h30; tk();
    check("R2", alarm_flag_o, 1'b0, "enabled mismatched hour blocks");
    wr(3'd1, 8'h91);               // hour excluded, value differs
    cur_min_i = 7'h31; tk();
    cur_min_i = 7'h30; tk();
    check("R2", alarm_flag_o, 1'b1, "excluded hour ignored");

    cur_req = "R10";
    wr(3'd4, 8'h00);
    wr(3'd2, 8'h15);
    wr(3'd3, 8'h04);               // weekday enabled, mismatched
    cur_min_i = 7'h31; tk();
    cur_min_i = 7'h30; tk();
    check("R10", alarm_flag_o, 1'b0, "weekday select 3 blocks");
    wr(3'd3, 8'h03);
    cur_min_i = 7'h31; tk();
    cur_min_i = 7'h30; tk();
    check("R10", alarm_flag_o, 1'b1, "day+weekday match");

    cur_req = "R9";
    wr(3'd4, 8'h00);
    cur_min_i = 7'h31; tk();
    cur_min_i = 7'h30;
    step(1, 1, 3'd4, 8'h00);
    check("R9", alarm_flag_o, 1'b1, "set beats clear");

    cur_req = "R7";
    wr(3'd4, 8'h00);
    wr(3'd0, 8'hB0); wr(3'd1, 8'h92); wr(3'd2, 8'h95); wr(3'd3, 8'h83);
    cur_min_i = 7'h31; tk();
    cur_min_i = 7'h30; tk();
    check("R7", alarm_flag_o, 1'b0, "all excluded after writes");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule